// File: doc/BRIEF.md
# Round-Robin Difference-of-Gaussian Packer

This unit sits right after a time-multiplexed Gaussian convolver. The convolver sends one smoothed sample per cycle and walks through all `NUM_DOG+1` blur levels of one pixel position before it moves to the next position. The unit subtracts each blur level from the one that follows it. One subtractor and one delay register handle every pair of levels, because the levels arrive in a fixed rotation.

The `NUM_DOG` signed differences of a position are collected lane by lane. When the last level of the position arrives, they are released as one wide word with a one-cycle valid. The DoG line buffers downstream can then store a whole position in one write. A stall input freezes the unit completely.

Smoothed samples are unsigned, `GAUSS_W` bits wide, with `GAUSS_W < DOG_W`. Every difference is therefore exact in `DOG_W`-bit two's complement and never saturates.

Top module: `dogrr_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `dog_valid_o` is 0 and `dog_word_o` is all zeros.
- R2: Lane j of `dog_word_o` occupies bits `[j*DOG_W +: DOG_W]`. It holds g(j+1) − g(j), where g(k) is the sample accepted with `px_scale_i == k` for the same pixel position.
- R3: Differences are signed two's complement in `DOG_W` bits. A falling blur level gives a negative lane value, and the full-scale values 0 and 2^GAUSS_W−1 give exact results.
- R4: A sample with scale index 0 produces no difference and only starts a new group. The word appears only after index `NUM_DOG` is accepted as the last step of an in-order run 0,1,…,`NUM_DOG`. `dog_valid_o` rises in the cycle after the clock edge that accepts that last sample.
- R5: Without stall, `dog_valid_o` is high for exactly one cycle per completed group.
- R6: Cycles with `px_valid_i` low change nothing. A group may be spread over cycles with gaps between its samples.
- R7: While `stall_i` is high, the input is ignored. The delay register and the collection counter keep their values, and `dog_valid_o` and `dog_word_o` hold their current values.
- R8: A scale index 0 that arrives before a group is complete discards the partial group and starts a new one.
- R9: A scale index other than the expected next one discards the group. No word is produced until a new run starting at index 0 completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Freeze all state and outputs; input ignored |
| px_valid_i | input | 1 | Smoothed sample present |
| px_value_i | input | GAUSS_W | Unsigned smoothed sample |
| px_scale_i | input | $clog2(NUM_DOG+1) | Blur level index of the sample |
| dog_valid_o | output | 1 | Packed word valid |
| dog_word_o | output | NUM_DOG*DOG_W | Packed signed differences, lane 0 lowest |

## Verification
The checker assumes that every valid scale index is at most `NUM_DOG`. The bench keeps to this: it uses indices out of order to exercise group discard, but never out of range. The pulse and stall properties rest on the convolver's rotation, in which a new group cannot finish in the cycle right after another one. The bench drives groups back to back, with idle gaps, with a stall in the middle of a group, with stalls that cover a pending word, and with restarted and broken runs.

// File: rtl/dogrr_pkg.sv
package dogrr_pkg;

    localparam int DEF_GAUSS_W = 12;
    localparam int DEF_DOG_W   = 16;
    localparam int DEF_NUM_DOG = 4;

    // What the packer does with the current input cycle
    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_START,
        ACT_STORE,
        ACT_EMIT,
        ACT_DROP
    } pack_act_e;

    function automatic pack_act_e classify(
        input logic take,
        input int   scale,
        input int   expect_idx,
        input int   last_idx
    );
        if (!take)                     return ACT_NONE;
        if (scale == expect_idx) begin
            if (scale == last_idx)     return ACT_EMIT;
            if (scale == 0)            return ACT_START;
            return ACT_STORE;
        end
        if (scale == 0)                return ACT_START;
        return ACT_DROP;
    endfunction

endpackage

// File: rtl/dogrr_diff.sv
module dogrr_diff #(
    parameter int GAUSS_W = dogrr_pkg::DEF_GAUSS_W,
    parameter int DOG_W   = dogrr_pkg::DEF_DOG_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take_i,
    input  logic [GAUSS_W-1:0] value_i,
    output logic [DOG_W-1:0]   diff_o
);
    logic [GAUSS_W-1:0] hold_q;

    // Single shared subtractor: current level minus previous level
    assign diff_o = DOG_W'(value_i) - DOG_W'(hold_q);

    always_ff @(posedge clk) begin
        if (rst)         hold_q <= '0;
        else if (take_i) hold_q <= value_i;
    end
endmodule

// File: rtl/dogrr_pack.sv
module dogrr_pack
    import dogrr_pkg::*;
#(
    parameter int DOG_W   = DEF_DOG_W,
    parameter int NUM_DOG = DEF_NUM_DOG,
    localparam int SCALE_W = $clog2(NUM_DOG + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     stall_i,
    input  logic                     valid_i,
    input  logic [SCALE_W-1:0]       scale_i,
    input  logic [DOG_W-1:0]         diff_i,
    output logic                     dog_valid_o,
    output logic [NUM_DOG*DOG_W-1:0] dog_word_o
);
    localparam logic [SCALE_W-1:0] LAST_IDX = SCALE_W'(NUM_DOG);

    pack_act_e               act;
    logic [SCALE_W-1:0]      cnt_q;
    logic [DOG_W-1:0]        slot_q [NUM_DOG-1];
    logic [NUM_DOG*DOG_W-1:0] word_nxt;

    assign act = classify(valid_i && !stall_i, int'(scale_i), int'(cnt_q), NUM_DOG);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case (act)
                ACT_START: cnt_q <= SCALE_W'(1);
                ACT_STORE: cnt_q <= cnt_q + SCALE_W'(1);
                ACT_EMIT,
                ACT_DROP:  cnt_q <= '0;
                default:   cnt_q <= cnt_q;
            endcase
        end
    end

    for (genvar j = 0; j < NUM_DOG - 1; j++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[j] <= '0;
            else if (act == ACT_STORE && scale_i == SCALE_W'(j + 1))
                slot_q[j] <= diff_i;
        end
        assign word_nxt[j*DOG_W +: DOG_W] = slot_q[j];
    end
    assign word_nxt[(NUM_DOG-1)*DOG_W +: DOG_W] = diff_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            dog_valid_o <= 1'b0;
            dog_word_o  <= '0;
        end else if (!stall_i) begin
            dog_valid_o <= (act == ACT_EMIT);
            if (act == ACT_EMIT && scale_i == LAST_IDX)
                dog_word_o <= word_nxt;
        end
    end
endmodule

// File: rtl/dogrr_unit.sv
module dogrr_unit
    import dogrr_pkg::*;
#(
    parameter int GAUSS_W = DEF_GAUSS_W,
    parameter int DOG_W   = DEF_DOG_W,
    parameter int NUM_DOG = DEF_NUM_DOG,
    localparam int SCALE_W = $clog2(NUM_DOG + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     stall_i,
    input  logic                     px_valid_i,
    input  logic [GAUSS_W-1:0]       px_value_i,
    input  logic [SCALE_W-1:0]       px_scale_i,
    output logic                     dog_valid_o,
    output logic [NUM_DOG*DOG_W-1:0] dog_word_o
);
    logic [DOG_W-1:0] diff;

    dogrr_diff #(.GAUSS_W(GAUSS_W), .DOG_W(DOG_W)) diff_i (
        .clk     (clk),
        .rst     (rst),
        .take_i  (px_valid_i && !stall_i),
        .value_i (px_value_i),
        .diff_o  (diff)
    );

    dogrr_pack #(.DOG_W(DOG_W), .NUM_DOG(NUM_DOG)) pack_i (
        .clk         (clk),
        .rst         (rst),
        .stall_i     (stall_i),
        .valid_i     (px_valid_i),
        .scale_i     (px_scale_i),
        .diff_i      (diff),
        .dog_valid_o (dog_valid_o),
        .dog_word_o  (dog_word_o)
    );
endmodule

// File: rtl/dogrr_unit_chk.sv
module dogrr_unit_chk #(
    parameter int GAUSS_W = dogrr_pkg::DEF_GAUSS_W,
    parameter int DOG_W   = dogrr_pkg::DEF_DOG_W,
    parameter int NUM_DOG = dogrr_pkg::DEF_NUM_DOG,
    localparam int SCALE_W = $clog2(NUM_DOG + 1)
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     stall_i,
    input logic                     px_valid_i,
    input logic [GAUSS_W-1:0]       px_value_i,
    input logic [SCALE_W-1:0]       px_scale_i,
    input logic                     dog_valid_o,
    input logic [NUM_DOG*DOG_W-1:0] dog_word_o
);
    AST_IDLE_NO_WORD: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && !px_valid_i) |=> !dog_valid_o); // R6

    AST_ONLY_LAST_EMITS: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && px_valid_i && px_scale_i != SCALE_W'(NUM_DOG)) |=> !dog_valid_o); // R4

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> ($stable(dog_valid_o) && $stable(dog_word_o))); // R7

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (dog_valid_o && !stall_i) |=> !dog_valid_o); // R5

    AST_SCALE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        px_valid_i |-> (px_scale_i <= SCALE_W'(NUM_DOG))); // R9

    // px_value_i is observed only through the outputs
    logic unused_ok;
    assign unused_ok = ^px_value_i;
endmodule

bind dogrr_unit dogrr_unit_chk #(
    .GAUSS_W(GAUSS_W), .DOG_W(DOG_W), .NUM_DOG(NUM_DOG)
) chk_i (.*);

// File: tb/dogrr_unit_tb_top.sv
`timescale 1ns/1ps
module dogrr_unit_tb_top;
    localparam int GW = 12;
    localparam int DW = 16;
    localparam int ND = 4;
    localparam int SW = $clog2(ND + 1);
    localparam int WW = ND * DW;

    typedef int grp_t [ND+1];

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stall_i = 1'b0;
    logic          px_valid_i = 1'b0;
    logic [GW-1:0] px_value_i = '0;
    logic [SW-1:0] px_scale_i = '0;
    logic          dog_valid_o;
    logic [WW-1:0] dog_word_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk; // 250 MHz

    dogrr_unit #(.GAUSS_W(GW), .DOG_W(DW), .NUM_DOG(ND)) dut_i (.*);

    function automatic logic [WW-1:0] exp_word(grp_t g);
        logic [WW-1:0] w;
        for (int j = 0; j < ND; j++) w[j*DW +: DW] = DW'(g[j+1] - g[j]);
        return w;
    endfunction

    task automatic chk(string req, logic [WW-1:0] act, logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(int v, int s);
        @(negedge clk);
        px_valid_i = 1'b1;
        px_value_i = GW'(v);
        px_scale_i = SW'(s);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            px_valid_i = 1'b0;
        end
    endtask

    // Drive a full group, optionally with gaps; check the word and the pulse
    task automatic run_group(string req, grp_t g, int gap);
        for (int s = 0; s <= ND; s++) begin
            drive(g[s], s);
            if (gap > 0 && s < ND) idle(gap);
        end
        @(posedge clk); #1;
        chk({req, " valid"}, WW'(dog_valid_o), WW'(1));
        chk({req, " word"}, dog_word_o, exp_word(g));
        idle(1);
        @(posedge clk); #1;
        chk("R5 pulse ends", WW'(dog_valid_o), WW'(0));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset valid", WW'(dog_valid_o), WW'(0));
        chk("R1 reset word", dog_word_o, '0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 after reset", WW'(dog_valid_o), WW'(0));
    endtask

    task automatic t_basic();
        grp_t g1 = '{100, 150, 230, 300, 420};
        grp_t g2 = '{10, 20, 40, 80, 160};
        run_group("R2 ascending", g1, 0);
        run_group("R2 second group", g2, 0);
    endtask

    task automatic t_signed();
        grp_t g1 = '{900, 700, 701, 200, 50};
        grp_t g2 = '{0, 4095, 0, 4095, 0};
        run_group("R3 falling", g1, 0);
        run_group("R3 extremes", g2, 0);
    endtask

    task automatic t_gaps();
        grp_t g = '{5, 60, 61, 3000, 2999};
        run_group("R6 gapped", g, 2);
    endtask

    task automatic t_stall_mid();
        grp_t g = '{400, 410, 390, 1000, 1};
        drive(g[0], 0); drive(g[1], 1); drive(g[2], 2);
        // stalled junk that must be ignored
        @(negedge clk);
        stall_i = 1'b1; px_value_i = GW'(4000); px_scale_i = SW'(3);
        repeat (3) @(negedge clk);
        px_scale_i = SW'(4);
        @(posedge clk); #1;
        chk("R7 stall no word", WW'(dog_valid_o), WW'(0));
        @(negedge clk); stall_i = 1'b0;
        px_valid_i = 1'b0;
        drive(g[3], 3); drive(g[4], 4);
        @(posedge clk); #1;
        chk("R7 resumed word", dog_word_o, exp_word(g));
        // stall while the word is pending: it must be held
        @(negedge clk); stall_i = 1'b1; px_valid_i = 1'b1; px_scale_i = SW'(0);
        repeat (2) @(posedge clk);
        #1;
        chk("R7 held valid", WW'(dog_valid_o), WW'(1));
        chk("R7 held word", dog_word_o, exp_word(g));
        @(negedge clk); stall_i = 1'b0; px_valid_i = 1'b0;
        @(posedge clk); #1;
        chk("R5 pulse after stall", WW'(dog_valid_o), WW'(0));
    endtask

    task automatic t_restart();
        grp_t g = '{77, 78, 80, 83, 87};
        drive(1000, 0); drive(2000, 1); drive(3000, 2);
        @(posedge clk); #1;
        chk("R4 partial no word", WW'(dog_valid_o), WW'(0));
        run_group("R8 restarted", g, 0);
    endtask

    task automatic t_out_of_order();
        drive(10, 0); drive(20, 1); drive(30, 3); drive(40, 4);
        @(posedge clk); #1;
        chk("R9 skip discards", WW'(dog_valid_o), WW'(0));
        drive(50, 2); drive(60, 3); drive(70, 4);
        @(posedge clk); #1;
        chk("R9 no run from mid", WW'(dog_valid_o), WW'(0));
        idle(1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_signed();
        t_gaps();
        t_stall_mid();
        t_restart();
        t_out_of_order();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule